// File: doc/BRIEF.md
# Byte Serial Link Controller with Mode-Fault Guard

This block moves one byte at a time over a four-wire synchronous serial link, as either the clock-driving master or a selected slave. Software reaches it through a small register bus with three locations. Address 0 is the control register, address 1 the control/status register and address 2 the data register. In master mode a write to the data register starts an eight-bit exchange. The serial clock is derived from the system clock by a fixed divider. When the exchange ends, the received byte is parked in a read buffer and a completion flag is raised.

Two flags feed a single interrupt request: completion and mode fault. Each flag clears only through a two-step access sequence. While completion is pending, data writes are locked out. A slave-select level seen low while the block is master is treated as a bus conflict. The block then drops out of master mode and releases every pin it drives. The slave-select level can come from the pin or from a software bit. The serial data output can be tri-stated by software.

The register bus is a plain strobe interface with no stall: every `bus_wr` or `bus_rd` pulse completes in the cycle it is seen. `bus_rdata` is a combinational view of the addressed register. Read side effects take place at the clock edge that ends the strobe cycle.

Top module: `spi_ctl`

## Requirements
- R1: After reset, the control and control/status registers read 0x00, `irq` is 0 and `sck_oe`, `mosi_oe` and `miso_oe` are all 0.
- R2: With control bits enable (bit 6) and master (bit 4) set, a data-register write starts one exchange. Eight rising `sck_o` edges follow, with SCK idle low and a period of 8 clocks. The byte goes out on `mosi_o` MSB first, and `miso_i` is sampled on each rising edge. The completion flag appears 64 clocks after the write.
- R3: At the end of an exchange, status bit 7 (done) becomes 1 and a data-register read returns the byte received.
- R4: While done is 1 and the status register has not been read since it was set, data-register writes are ignored and start no exchange.
- R5: Done is cleared only by a status-register read while it is 1, followed by a read or write of the data register. A data-register access without the preceding status read leaves it set.
- R6: When enable and master are both set and the internal slave select is low, status bit 4 (fault) is set. Enable and master are cleared, the exchange is aborted, and `sck_oe` and `mosi_oe` drop to 0.
- R7: Fault is cleared only by a status-register access while it is 1, followed by a control-register write. A control write without the preceding access leaves it set.
- R8: `irq` is 1 exactly when control bit 7 (interrupt enable) is 1 and done or fault is 1.
- R9: Status bit 3 always reads 0, even after being written as 1. Status bits 2..0 read back as written.
- R10: Status bit 2 (output disable) set to 1 holds `mosi_oe` (master) or `miso_oe` (slave) at 0. When it is 0, that output is enabled whenever enable is 1.
- R11: Status bit 1 (software select) set to 1 makes the internal slave select equal to status bit 0, with 0 meaning selected. When bit 1 is 0, the `ss_n_i` pin is used.
- R12: In slave mode (enable set, master clear, internal select low), a byte written to the data register is shifted out on `miso_o` MSB first. `mosi_i` is sampled on rising `sck_i` edges, and done is set after the eighth falling edge.
- R13: A data-register write during a master exchange is ignored, and the byte in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 control/status, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, carries read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock received as slave |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data out enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable |
| miso_i | input | 1 | Master data in |
| ss_n_i | input | 1 | Slave-select pin, active low |

## Verification
The hardest states to reach are the half-finished clearing sequences. In these, the flag is still set and the interrupt still asserted, but the block has been touched in the wrong order. Examples are a data access without the status read, or a control write before any status access after a fault. The stimulus produces the fault and completion through the ports alone and then performs the out-of-order access. It observes `irq`, SCK activity and the pin enables before any status read that would arm the clear. Only after that does it complete the proper sequence.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_DATA = 2'd2
  } reg_addr_e;

  // control register bits
  localparam int C_IEN = 7;
  localparam int C_PEN = 6;
  localparam int C_MST = 4;
  // control/status register bits
  localparam int S_DONE  = 7;
  localparam int S_FAULT = 4;
  localparam int S_ODIS  = 2;
  localparam int S_SSM   = 1;
  localparam int S_SSI   = 0;
endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;
  logic          sck_q;

  assign rise = run && (cnt == CW'(HALF - 1));
  assign fall = run && (cnt == CW'(DIV - 1));
  assign sck  = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt <= fall ? '0 : cnt + 1'b1;
      if (rise) sck_q <= 1'b1;
      if (fall) sck_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         rise,
  input  logic         fall,
  input  logic         sin,
  output logic         sout,
  output logic         fin,
  output logic         mid,
  output logic [W-1:0] rx
);
  localparam int BCW = (W > 2) ? $clog2(W) : 1;

  logic [W-1:0]   sh;
  logic           samp;
  logic [BCW-1:0] bcnt;

  assign sout = sh[W-1];
  assign rx   = {sh[W-2:0], samp};
  assign mid  = (bcnt != '0);
  assign fin  = fall && (bcnt == BCW'(W - 1)) && !clr && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      samp <= 1'b0;
      bcnt <= '0;
    end else if (clr) begin
      bcnt <= '0;
    end else if (load) begin
      sh   <= ld_data;
      bcnt <= '0;
    end else begin
      if (rise) samp <= sin;
      if (fall) begin
        sh   <= {sh[W-2:0], samp};
        bcnt <= (bcnt == BCW'(W - 1)) ? '0 : bcnt + 1'b1;
      end
    end
  end

  AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall)); // R2
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i,
  input  logic       ss_n_i
);
  // register state
  logic ien, pen, mst;
  logic done, fault, odis, ssm, ssi;
  logic done_arm, fault_arm, busy;
  logic [BYTE_W-1:0] rxbuf;

  // input synchronizers
  logic [2:0] sck_sy;
  logic [1:0] mosi_sy, ss_sy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      mosi_sy <= '0;
      ss_sy   <= '1;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
    end
  end

  // bus decode
  logic wr_ctrl, wr_stat, rd_stat, acc_stat, acc_data, wr_data;
  assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
  assign wr_stat  = bus_wr && (bus_addr == RA_STAT);
  assign rd_stat  = bus_rd && (bus_addr == RA_STAT);
  assign acc_stat = (bus_wr || bus_rd) && (bus_addr == RA_STAT);
  assign acc_data = (bus_wr || bus_rd) && (bus_addr == RA_DATA);
  assign wr_data  = bus_wr && (bus_addr == RA_DATA);

  // select, fault and edge sources
  logic ss_int, fault_hit, slv_on;
  logic m_rise, m_fall, s_rise, s_fall, sck_q;
  logic sh_fin, sh_mid, sh_out, sh_clr, sh_load, sh_rise, sh_fall, sh_in;
  logic [BYTE_W-1:0] sh_rx;

  assign ss_int    = ssm ? ssi : ss_sy[1];
  assign fault_hit = pen && mst && !ss_int;
  assign slv_on    = pen && !mst && !ss_int;
  assign s_rise    = slv_on && sck_sy[1] && !sck_sy[2];
  assign s_fall    = slv_on && !sck_sy[1] && sck_sy[2];

  logic dr_lock, wr_ok, start;
  assign dr_lock = done && !done_arm;
  assign wr_ok   = wr_data && !dr_lock && pen && !fault_hit &&
                   (mst ? !busy : (!sh_mid && slv_on));
  assign start   = wr_ok && mst;

  assign sh_clr  = fault_hit || (!mst && !slv_on);
  assign sh_load = wr_ok;
  assign sh_rise = mst ? m_rise : s_rise;
  assign sh_fall = mst ? m_fall : s_fall;
  assign sh_in   = mst ? miso_i : mosi_sy[1];

  spi_clkdiv #(.DIV(DIV)) u_clkdiv (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .sck  (sck_q),
    .rise (m_rise),
    .fall (m_fall)
  );

  spi_shifter #(.W(BYTE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sh_clr),
    .load   (sh_load),
    .ld_data(bus_wdata),
    .rise   (sh_rise),
    .fall   (sh_fall),
    .sin    (sh_in),
    .sout   (sh_out),
    .fin    (sh_fin),
    .mid    (sh_mid),
    .rx     (sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= 1'b0; pen <= 1'b0; mst <= 1'b0;
      odis <= 1'b0; ssm <= 1'b0; ssi <= 1'b0;
      done <= 1'b0; done_arm <= 1'b0;
      fault <= 1'b0; fault_arm <= 1'b0;
      busy <= 1'b0;
      rxbuf <= '0;
    end else begin
      if (wr_ctrl) begin
        ien <= bus_wdata[C_IEN];
        pen <= bus_wdata[C_PEN];
        mst <= bus_wdata[C_MST];
      end
      if (wr_stat) begin
        odis <= bus_wdata[S_ODIS];
        ssm  <= bus_wdata[S_SSM];
        ssi  <= bus_wdata[S_SSI];
      end

      // mode fault and its clearing sequence
      if (fault_hit) begin
        fault <= 1'b1;
        pen   <= 1'b0;
        mst   <= 1'b0;
      end else if (wr_ctrl && fault_arm) begin
        fault     <= 1'b0;
        fault_arm <= 1'b0;
      end else if (acc_stat && fault) begin
        fault_arm <= 1'b1;
      end

      // completion and its clearing sequence
      if (sh_fin) begin
        done     <= 1'b1;
        done_arm <= 1'b0;
        rxbuf    <= sh_rx;
      end else if (acc_data && done_arm) begin
        done     <= 1'b0;
        done_arm <= 1'b0;
      end else if (rd_stat && done) begin
        done_arm <= 1'b1;
      end

      // master exchange in flight
      if (fault_hit)          busy <= 1'b0;
      else if (start)         busy <= 1'b1;
      else if (sh_fin && mst) busy <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL: begin
        bus_rdata[C_IEN] = ien;
        bus_rdata[C_PEN] = pen;
        bus_rdata[C_MST] = mst;
      end
      RA_STAT: begin
        bus_rdata[S_DONE]  = done;
        bus_rdata[S_FAULT] = fault;
        bus_rdata[S_ODIS]  = odis;
        bus_rdata[S_SSM]   = ssm;
        bus_rdata[S_SSI]   = ssi;
      end
      RA_DATA: bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = ien && (done || fault);
  assign sck_o   = sck_q;
  assign sck_oe  = pen && mst;
  assign mosi_o  = sh_out;
  assign mosi_oe = pen && mst && !odis;
  assign miso_o  = sh_out;
  assign miso_oe = pen && !mst && !odis;

  AST_FAULT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!mst && !pen && !busy && !sck_oe)); // R6
  AST_FAULT_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> ($past(bus_wr) && $past(bus_addr) == RA_CTRL)); // R7
  AST_DONE_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> (($past(bus_wr) || $past(bus_rd)) && $past(bus_addr) == RA_DATA)); // R5
  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && done && !done_arm && !busy) |=> !busy); // R4
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy) |-> !sck_o); // R2
endmodule

// File: tb/spi_ctl_tb.sv
module spi_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic miso_i;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  // bench-side slave answering the master
  logic [7:0] mpat = '0;
  logic [7:0] cap = '0;
  int edges = 0;
  assign miso_i = mpat[7];
  always @(negedge sck_o) mpat <= {mpat[6:0], 1'b0};
  always @(posedge sck_o) begin
    cap   <= {cap[6:0], mosi_o};
    edges <= edges + 1;
  end

  spi_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
    .ss_n_i(ss_n_i)
  );

  // {tx byte, byte returned on miso}
  localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h8101};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic arm_bench(input logic [7:0] m);
    mpat = m; cap = '0; edges = 0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v, sc;
    int n;
    ticks(3);
    rst_n = 1'b1;
    ticks(2);

    // R1 reset state
    brd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    brd(2'd1, v); chk("R1 stat", v, 8'h00);
    chk("R1 irq/oe", {4'b0, irq, sck_oe, mosi_oe, miso_oe}, 8'h00);

    // R9 reserved bit
    bwr(2'd1, 8'h0F);
    brd(2'd1, v); chk("R9 stat readback", v, 8'h07);

    // R10 output disable in master mode
    bwr(2'd1, 8'h03);
    bwr(2'd0, 8'hD0);
    chk("R10 master oe", {6'b0, sck_oe, mosi_oe}, 8'h03);
    bwr(2'd1, 8'h07);
    chk("R10 master odis", {6'b0, sck_oe, mosi_oe}, 8'h02);
    bwr(2'd1, 8'h03);

    // R2 R3 R5 vector walk
    for (int k = 0; k < 4; k++) begin
      arm_bench(VEC[k][7:0]);
      bwr(2'd2, VEC[k][15:8]);
      wait_irq(n);
      chk("R2 cycles", 8'(n), 8'd64);
      chk("R2 edges", 8'(edges), 8'd8);
      chk("R2 mosi byte", cap, VEC[k][15:8]);
      brd(2'd1, v); chk("R3 done", v, 8'h83);
      brd(2'd2, v); chk("R3 rx byte", v, VEC[k][7:0]);
      brd(2'd1, v); chk("R5 cleared", v, 8'h03);
    end

    // R13 write during exchange
    arm_bench(8'h00);
    bwr(2'd2, 8'h96);
    ticks(10);
    bwr(2'd2, 8'h11);
    wait_irq(n);
    chk("R13 byte kept", cap, 8'h96);
    chk("R13 edges", 8'(edges), 8'd8);
    brd(2'd1, v); brd(2'd2, v);

    // R4 R5 lock and clear ordering
    arm_bench(8'h00);
    bwr(2'd2, 8'h5A);
    wait_irq(n);
    arm_bench(8'h00);
    bwr(2'd2, 8'h22);
    ticks(80);
    chk("R4 no start", 8'(edges), 8'd0);
    brd(2'd2, v);
    chk("R5 still set", {7'b0, irq}, 8'h01);
    brd(2'd1, v); chk("R5 stat", v, 8'h83);
    bwr(2'd2, 8'hC3);
    ticks(2);
    chk("R5 clear by write", {7'b0, irq}, 8'h00);
    wait_irq(n);
    chk("R4 after unlock", cap, 8'hC3);
    brd(2'd1, v); brd(2'd2, v);

    // R8 interrupt enable off
    bwr(2'd0, 8'h50);
    arm_bench(8'h00);
    bwr(2'd2, 8'h01);
    ticks(80);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    brd(2'd1, v); chk("R8 done set", v, 8'h83);
    brd(2'd2, v);

    // R11 software select wins over low pin
    ss_n_i = 1'b0;
    bwr(2'd0, 8'hD0);
    ticks(6);
    brd(2'd1, v); chk("R11 ssi high no fault", v, 8'h03);
    brd(2'd0, v); chk("R11 ctrl kept", v, 8'hD0);

    // R6 R7 fault from software select
    bwr(2'd1, 8'h02);
    ticks(4);
    chk("R6 R8 ports", {5'b0, irq, sck_oe, mosi_oe}, 8'h04);
    brd(2'd0, v); chk("R6 ctrl", v, 8'h80);
    bwr(2'd0, 8'h80);
    chk("R7 early ctrl write", {7'b0, irq}, 8'h01);
    brd(2'd1, v); chk("R6 stat", v, 8'h12);
    bwr(2'd0, 8'h00);
    brd(2'd1, v); chk("R7 cleared", v, 8'h02);

    // R11 pin select
    bwr(2'd1, 8'h00);
    bwr(2'd0, 8'h50);
    ticks(4);
    brd(2'd1, v); chk("R11 pin fault", v, 8'h10);
    bwr(2'd0, 8'h00);
    brd(2'd1, v); chk("R7 pin fault cleared", v, 8'h00);

    // R10 R12 slave mode
    bwr(2'd0, 8'h40);
    ticks(4);
    chk("R10 slave oe", {7'b0, miso_oe}, 8'h01);
    bwr(2'd1, 8'h04);
    chk("R10 slave odis", {7'b0, miso_oe}, 8'h00);
    bwr(2'd1, 8'h00);
    bwr(2'd2, 8'h3C);
    sc = '0;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = 1'(8'hB4 >> i);
      ticks(6);
      sc = {sc[6:0], miso_o};
      sck_i = 1'b1;
      ticks(6);
      sck_i = 1'b0;
      ticks(6);
    end
    ticks(4);
    chk("R12 miso byte", sc, 8'h3C);
    brd(2'd1, v); chk("R12 done", v, 8'h80);
    brd(2'd2, v); chk("R12 rx byte", v, 8'hB4);

    report();
  end
endmodule